// File: doc/BRIEF.md
# Specific Address Receive Filter

This block decides whether the destination address of a received Ethernet frame matches one of four programmable specific-address slots. Software loads each slot through a 32-bit register write port. Each slot spans two words: a low word and then a high word. Each slot has its own active flag. A write to the low word takes the slot out of matching. A later write to the high word brings it back. Software can therefore rewrite a slot's address without the half-written value ever matching.

The receive path presents a 48-bit destination address with a valid strobe. One clock later the block reports its result:

- whether an active slot matched;
- which slot matched, searching from the highest index down;
- a result code, which is a base accept value plus the slot index;
- a separate flag for the all-ones broadcast address.

A read port returns any stored register word.

Top module: `saf_top`

## Requirements
- R1: After reset all four active flags are clear and every stored word reads 0. `hit`, `bcast` and `hit_slot` are 0, and `res_code` is the no-match code 0.
- R2: A write with an even word offset stores the data in the low word of slot `offset[2:1]` and clears that slot's active flag.
- R3: A write with an odd word offset stores the data in the high word of slot `offset[2:1]` and sets that slot's active flag.
- R4: A slot matches only when it is active and `dest_addr` equals {high[15:0], low[31:0]}. Bits 31:16 of the high word are ignored. Byte 0 of the frame is `dest_addr[7:0]`.
- R5: When several active slots match, the highest index is reported in `hit_slot`.
- R6: On a match `res_code` = 4 + index. With no match `res_code` = 0, `hit` = 0 and `hit_slot` = 0.
- R7: `bcast` is 1 exactly when the compared address is 48'hFFFF_FFFF_FFFF, whatever the slot contents.
- R8: The results are registered one cycle after `addr_valid`. While `addr_valid` is low, all results hold their values.
- R9: A register write in the same cycle as a compare does not affect that compare. It takes effect from the next compare onward.
- R10: `rd_data` shows the full 32-bit word at `rd_off` combinationally, using the same offset layout as writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_off | input | 3 | Word offset: slot in bits 2:1, high word when bit 0 is set |
| wr_data | input | 32 | Write data |
| rd_off | input | 3 | Read word offset |
| rd_data | output | 32 | Read data |
| addr_valid | input | 1 | Destination address valid |
| dest_addr | input | 48 | Destination address, byte 0 in bits 7:0 |
| hit | output | 1 | An active slot matched |
| hit_slot | output | 2 | Index of the matching slot |
| res_code | output | 4 | Result code |
| bcast | output | 1 | Address was broadcast |

## Verification
The properties assume a single write per cycle and address offsets in the range 0 to 7, which the 3-bit offset guarantees. They also assume that a result is only meaningful on the cycle after `addr_valid`. The stimulus drives inputs only between clock edges. It mixes three kinds of destination address: ones copied from the model's slot contents, the broadcast pattern, and random values. This makes hits, ties, disabled slots and misses all occur. It also places writes to both halves of a slot in the same cycles as compares, so the rule that a write takes effect at the next compare is exercised.

// File: rtl/saf_pkg.sv
package saf_pkg;
  localparam int unsigned SAF_SLOTS  = 4;
  localparam int unsigned SAF_DATA_W = 32;
  localparam int unsigned SAF_ADDR_W = 48;
  localparam int unsigned SAF_CODE_W = 4;
  localparam int unsigned SAF_BASE   = 4;
endpackage

// File: rtl/saf_slot_bank.sv
module saf_slot_bank #(
  parameter int unsigned N_SLOTS = saf_pkg::SAF_SLOTS,
  parameter int unsigned DATA_W  = saf_pkg::SAF_DATA_W,
  localparam int unsigned OFF_W  = $clog2(2 * N_SLOTS)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [OFF_W-1:0]                wr_off,
  input  logic [DATA_W-1:0]               wr_data,
  input  logic [OFF_W-1:0]                rd_off,
  output logic [DATA_W-1:0]               rd_data,
  output logic [N_SLOTS-1:0][DATA_W-1:0]  lo_words,
  output logic [N_SLOTS-1:0][DATA_W-1:0]  hi_words,
  output logic [N_SLOTS-1:0]              active
);
  for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
    logic             sel_lo, sel_hi;
    logic [DATA_W-1:0] lo_d, hi_d;
    logic             act_d;

    always_comb begin
      sel_lo = wr_en && (wr_off == OFF_W'(2 * g));
      sel_hi = wr_en && (wr_off == OFF_W'(2 * g + 1));
      lo_d   = sel_lo ? wr_data : lo_words[g];
      hi_d   = sel_hi ? wr_data : hi_words[g];
      act_d  = active[g];
      if (sel_lo) act_d = 1'b0;
      if (sel_hi) act_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_words[g] <= '0;
        hi_words[g] <= '0;
        active[g]   <= 1'b0;
      end else if (sel_lo || sel_hi) begin
        lo_words[g] <= lo_d;
        hi_words[g] <= hi_d;
        active[g]   <= act_d;
      end
    end
  end

  always_comb begin
    if (rd_off[0]) rd_data = hi_words[rd_off[OFF_W-1:1]];
    else           rd_data = lo_words[rd_off[OFF_W-1:1]];
  end
endmodule

// File: rtl/saf_matcher.sv
module saf_matcher #(
  parameter int unsigned N_SLOTS = saf_pkg::SAF_SLOTS,
  parameter int unsigned DATA_W  = saf_pkg::SAF_DATA_W,
  parameter int unsigned ADDR_W  = saf_pkg::SAF_ADDR_W,
  localparam int unsigned IDX_W  = $clog2(N_SLOTS),
  localparam int unsigned HI_W   = ADDR_W - DATA_W
) (
  input  logic [ADDR_W-1:0]               dest,
  input  logic [N_SLOTS-1:0][DATA_W-1:0]  lo_words,
  input  logic [N_SLOTS-1:0][DATA_W-1:0]  hi_words,
  input  logic [N_SLOTS-1:0]              active,
  output logic                            any_hit,
  output logic [IDX_W-1:0]                hit_idx,
  output logic                            is_bcast
);
  logic [N_SLOTS-1:0] eq;

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_cmp
    assign eq[g] = active[g] &&
                   (dest == {hi_words[g][HI_W-1:0], lo_words[g]});
  end

  // Ascending scan: the last (highest) matching index overrides.
  always_comb begin
    any_hit = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < N_SLOTS; i++) begin
      if (eq[i]) begin
        any_hit = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end

  assign is_bcast = &dest;
endmodule

// File: rtl/saf_top.sv
module saf_top #(
  parameter int unsigned N_SLOTS = saf_pkg::SAF_SLOTS,
  parameter int unsigned DATA_W  = saf_pkg::SAF_DATA_W,
  parameter int unsigned ADDR_W  = saf_pkg::SAF_ADDR_W,
  parameter int unsigned CODE_W  = saf_pkg::SAF_CODE_W,
  parameter int unsigned BASE    = saf_pkg::SAF_BASE,
  localparam int unsigned OFF_W  = $clog2(2 * N_SLOTS),
  localparam int unsigned IDX_W  = $clog2(N_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [DATA_W-1:0] rd_data,
  input  logic              addr_valid,
  input  logic [ADDR_W-1:0] dest_addr,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_slot,
  output logic [CODE_W-1:0] res_code,
  output logic              bcast
);
  logic [N_SLOTS-1:0][DATA_W-1:0] lo_words, hi_words;
  logic [N_SLOTS-1:0]             slot_active;
  logic                           m_hit, m_bcast;
  logic [IDX_W-1:0]               m_idx;
  logic                           hit_d, bcast_d;
  logic [IDX_W-1:0]               slot_d;
  logic [CODE_W-1:0]              code_d;

  saf_slot_bank #(.N_SLOTS(N_SLOTS), .DATA_W(DATA_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_off(wr_off),
    .wr_data(wr_data), .rd_off(rd_off), .rd_data(rd_data),
    .lo_words(lo_words), .hi_words(hi_words), .active(slot_active)
  );

  saf_matcher #(.N_SLOTS(N_SLOTS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_match (
    .dest(dest_addr), .lo_words(lo_words), .hi_words(hi_words),
    .active(slot_active), .any_hit(m_hit), .hit_idx(m_idx),
    .is_bcast(m_bcast)
  );

  always_comb begin
    hit_d   = m_hit;
    slot_d  = m_hit ? m_idx : '0;
    code_d  = m_hit ? CODE_W'(BASE + m_idx) : '0;
    bcast_d = m_bcast;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit      <= 1'b0;
      hit_slot <= '0;
      res_code <= '0;
      bcast    <= 1'b0;
    end else if (addr_valid) begin
      hit      <= hit_d;
      hit_slot <= slot_d;
      res_code <= code_d;
      bcast    <= bcast_d;
    end
  end
endmodule

// File: rtl/saf_checker.sv
module saf_checker #(
  parameter int unsigned N_SLOTS = 4,
  parameter int unsigned ADDR_W  = 48,
  parameter int unsigned CODE_W  = 4,
  parameter int unsigned BASE    = 4,
  localparam int unsigned OFF_W  = $clog2(2 * N_SLOTS),
  localparam int unsigned IDX_W  = $clog2(N_SLOTS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [OFF_W-1:0]  wr_off,
  input logic              addr_valid,
  input logic [ADDR_W-1:0] dest_addr,
  input logic              hit,
  input logic [IDX_W-1:0]  hit_slot,
  input logic [CODE_W-1:0] res_code,
  input logic              bcast,
  input logic [N_SLOTS-1:0] slot_active
);
  assert_low_write_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_off[0]) |=> !slot_active[$past(wr_off[OFF_W-1:1])]);

  assert_high_write_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_off[0]) |=> slot_active[$past(wr_off[OFF_W-1:1])]);

  assert_hit_needs_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && slot_active == '0) |=> !hit);

  assert_code_tracks_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (res_code == CODE_W'(BASE + hit_slot)));

  assert_nohit_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (res_code == '0 && hit_slot == '0));

  assert_bcast_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |=> (bcast == &$past(dest_addr)));

  assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_valid |=> ($stable(hit) && $stable(hit_slot) && $stable(res_code) && $stable(bcast)));
endmodule

bind saf_top saf_checker #(.N_SLOTS(N_SLOTS), .ADDR_W(ADDR_W), .CODE_W(CODE_W), .BASE(BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_off(wr_off),
  .addr_valid(addr_valid), .dest_addr(dest_addr), .hit(hit),
  .hit_slot(hit_slot), .res_code(res_code), .bcast(bcast),
  .slot_active(slot_active)
);

// File: tb/saf_top_bench.sv
module saf_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_off = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_off = '0;
  logic [31:0] rd_data;
  logic        addr_valid = 1'b0;
  logic [47:0] dest_addr = '0;
  logic        hit;
  logic [1:0]  hit_slot;
  logic [3:0]  res_code;
  logic        bcast;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  always #4 clk = ~clk;

  saf_top u_saf_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_off(wr_off),
    .wr_data(wr_data), .rd_off(rd_off), .rd_data(rd_data),
    .addr_valid(addr_valid), .dest_addr(dest_addr), .hit(hit),
    .hit_slot(hit_slot), .res_code(res_code), .bcast(bcast)
  );

  // Behavioural reference model
  logic [31:0] m_lo [4];
  logic [31:0] m_hi [4];
  bit          m_act [4];
  bit          e_hit, e_bcast;
  int          e_slot, e_code;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_lo[i]) begin m_lo[i] = 0; m_hi[i] = 0; m_act[i] = 0; end
      e_hit = 0; e_slot = 0; e_code = 0; e_bcast = 0;
    end else begin
      if (addr_valid) begin            // compare on old contents (R9)
        e_hit = 0; e_slot = 0; e_code = 0;
        for (int s = 3; s >= 0; s--) begin
          if (!e_hit && m_act[s] && dest_addr == {m_hi[s][15:0], m_lo[s]}) begin
            e_hit = 1; e_slot = s; e_code = 4 + s;
          end
        end
        e_bcast = (dest_addr == 48'hFFFF_FFFF_FFFF);
      end
      if (wr_en) begin
        if (wr_off[0]) begin m_hi[wr_off[2:1]] = wr_data; m_act[wr_off[2:1]] = 1; end
        else           begin m_lo[wr_off[2:1]] = wr_data; m_act[wr_off[2:1]] = 0; end
      end
    end
  end

  task automatic check(input string tag, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("R4/R5 hit", hit, e_hit);
    check("R5 hit_slot", hit_slot, e_slot);
    check("R6 res_code", res_code, e_code);
    check("R7 bcast", bcast, e_bcast);
    check("R10 rd_data", rd_data, rd_off[0] ? m_hi[rd_off[2:1]] : m_lo[rd_off[2:1]]);
  endtask

  task automatic step();
    @(negedge clk);
    compare_all();
    wr_en = 0; addr_valid = 0;
  endtask

  task automatic wr(input int off, input logic [31:0] d);
    wr_en = 1; wr_off = 3'(off); wr_data = d; step();
  endtask

  task automatic cmp(input logic [47:0] a);
    addr_valid = 1; dest_addr = a; step();
  endtask

  initial begin
    #2000000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [47:0] A;
    A = 48'h1234_5678_9ABC;
    repeat (3) @(negedge clk);
    // R1: reset state
    for (int o = 0; o < 8; o++) begin
      rd_off = 3'(o); #1;
      check("R1 reset word", rd_data, 0);
    end
    check("R1 reset hit", hit, 0);
    check("R1 reset code", res_code, 0);
    check("R1 reset bcast", bcast, 0);
    rst_n = 1;
    @(negedge clk);
    cmp(48'h0);                              // R1: nothing active, zero address
    wr(2, A[31:0]); cmp(A);                  // R2: low only, inactive
    wr(3, {16'hDEAD, A[47:32]}); cmp(A);     // R3/R4: active, upper bits ignored
    wr(6, A[31:0]); wr(7, {16'h0, A[47:32]}); cmp(A);   // R5: slot 3 wins
    wr(6, A[31:0]); cmp(A);                  // R2: slot 3 disabled again
    cmp(48'hFFFF_FFFF_FFFF);                 // R7
    wr(0, 32'hFFFF_FFFF); wr(1, 32'h0000_FFFF); cmp(48'hFFFF_FFFF_FFFF);
    // R9: write in same cycle as compare
    addr_valid = 1; dest_addr = A; wr_en = 1; wr_off = 3'd2; wr_data = A[31:0]; step();
    cmp(A);
    addr_valid = 1; dest_addr = A; wr_en = 1; wr_off = 3'd7; wr_data = 32'h0; step();
    cmp(A);
    cmp(A);
    // R8: idle cycles hold
    repeat (3) step();
    // random traffic
    for (int n = 0; n < 3000; n++) begin
      int k;
      wr_en = ($urandom_range(0, 2) == 0);
      wr_off = 3'($urandom_range(0, 7));
      wr_data = ($urandom_range(0, 1) == 0) ? A[31:0] : {16'($urandom), 14'h0, 2'($urandom)};
      if (wr_off[0] && $urandom_range(0, 1) == 0) wr_data = {16'($urandom), A[47:32]};
      addr_valid = ($urandom_range(0, 3) != 0);
      k = $urandom_range(0, 5);
      if (k < 4) dest_addr = {m_hi[k][15:0], m_lo[k]};
      else if (k == 4) dest_addr = 48'hFFFF_FFFF_FFFF;
      else dest_addr = {16'($urandom), 32'($urandom)};
      rd_off = 3'($urandom_range(0, 7));
      step();
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule